// File: doc/BRIEF.md
# I2C Slave Engine with Selectable Clock-Stretch Point

This block is the slave side of an I2C bus interface. A system clock oversamples SCL and SDA. The block finds start and stop conditions and shifts in the address byte, which holds seven address bits and the direction bit. It then either acknowledges, recognises an extension code, or ignores the rest of the transfer. Once addressed, it receives bytes from the master or sends bytes to it. Both bus lines are open-drain: each output is a pull-low enable, and the block never drives a line high.

After every byte the engine holds SCL low and raises a one-cycle interrupt. Software chooses whether this happens at the eighth or the ninth falling SCL edge of the byte. Two cases override that choice. An address byte that matches the local address always waits at the ninth edge. An extension-code address always waits at the eighth edge, so that software can decide whether to acknowledge it. A stop condition can also raise the interrupt.

Received bytes leave on a valid/ready pair. `rx_valid_o` is high only while the bus is held after a received byte, and `rx_data_o` is stable for that whole time. The single-cycle `release_i` strobe is the ready: it accepts the byte and lets SCL go. The master cannot send more data until the release, so the bus itself supplies the back-pressure. Transmit data has no handshake. `tx_data` is sampled when a transmit byte starts: at the release of a ninth-edge wait, or at the ninth falling edge of the previous byte when eighth-edge waits are chosen.

Top module: `i2c_wait_slave`

## Requirements
- R1: After reset, and on the cycle after `if_en` is seen low, both pull-low outputs are 0, no interrupt occurs, and bus activity is ignored.
- R2: An address byte whose upper seven bits equal `own_addr` is acknowledged whatever `ack_en` is. SCL is then held low from the ninth falling edge, with one interrupt pulse, whatever `wait9_sel` is.
- R3: An address byte that neither matches nor is an extension code gets no acknowledge, no hold and no interrupt, and the following bytes are ignored until the next start.
- R4: An address byte whose upper four bits are 1111 is an extension code. It is held at the eighth falling edge with one interrupt and `ext_code_o`=1. After release, the ninth clock carries an acknowledge exactly when `ack_en`=1, and the data bytes that follow are received only in that case.
- R5: When `wait9_sel`=0 and the slave is receiving, each data byte is held at the eighth falling edge with one interrupt and `rx_valid_o`=1, with `rx_data_o` equal to the byte received MSB first. After release, the ninth clock carries an acknowledge exactly when `ack_en`=1.
- R6: When `wait9_sel`=1 and the slave is receiving, the ninth clock carries an acknowledge exactly when `ack_en`=1. The hold, the interrupt and `rx_valid_o` with the byte all come at the ninth falling edge.
- R7: After a matched address with direction bit 1, the slave sends `tx_data` MSB first. Its hold point follows `wait9_sel` (eighth or ninth edge). A master NACK on the ninth clock ends the transmission and releases SDA.
- R8: A stop condition raises one interrupt only when `stop_irq_en`=1 and `wake_mode`=0.
- R9: The control inputs `ack_en`, `wait9_sel`, `stop_irq_en` and `wake_mode` are captured only while `if_en`=0, and reset clears them. Changes made while `if_en`=1 have no effect.
- R10: A start condition at any point, including in the middle of a byte, abandons the current byte and restarts the bit count on a new address byte.
- R11: A release strobe during a hold lets SCL go on the next cycle, and `rx_data_o` does not change while `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| own_addr | input | ADDR_W | Local slave address |
| if_en | input | 1 | Interface enable; control inputs are captured while 0 |
| ack_en | input | 1 | Acknowledge data and extension-code bytes |
| wait9_sel | input | 1 | 0: hold at eighth falling edge, 1: at ninth |
| stop_irq_en | input | 1 | Allow an interrupt on a stop condition |
| wake_mode | input | 1 | Suppresses the stop interrupt when 1 |
| release_i | input | 1 | One-cycle strobe that ends a hold (ready for received bytes) |
| tx_data | input | ADDR_W+1 | Byte to send in transmit mode |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rx_valid_o | output | 1 | Received byte valid while the bus is held |
| rx_data_o | output | ADDR_W+1 | Last received byte |
| ext_code_o | output | 1 | The current address byte is an extension code |
| tx_mode_o | output | 1 | The slave is in transmit mode |

## Verification
The hardest case to reach from the ports is the repeated start in the middle of a data byte. The slave has to drop a partly counted byte and recount the new address from zero, and this shows only in where the next acknowledge and hold fall. The bench bit-bangs a few data bits, issues a fresh start while SCL is low, and then checks that the new address is acknowledged and held exactly at its ninth edge. The extension-code path with acknowledge disabled is also hard to reach: the slave has to go quiet after a hold it has already taken. Random transactions mix extension, matching and foreign addresses under random control settings to reach it often.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_RX, PH_TX} phase_t;
  typedef enum logic [1:0] {RA_NONE, RA_ACK, RA_LOAD} rel_act_t;
  typedef struct packed {
    logic ack_en;
    logic wait9;
    logic stop_en;
    logic wake;
  } cfg_t;
  localparam logic [3:0] EXT_NIBBLE = 4'hF;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] now_o,
  output logic [LINES-1:0] last_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw_i[g]};
    end
    assign now_o[g]  = pipe[STAGES-1];
    assign last_o[g] = pipe[STAGES];
  end
endmodule

// File: rtl/i2cw_cfg.sv
module i2cw_cfg
  import i2cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  cfg_t d_i,
  output cfg_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (!if_en) q_o <= d_i;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    if_en |=> $stable(q_o)); // R9
endmodule

// File: rtl/i2c_wait_slave.sv
module i2c_wait_slave
  import i2cw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              if_en,
  input  logic              ack_en,
  input  logic              wait9_sel,
  input  logic              stop_irq_en,
  input  logic              wake_mode,
  input  logic              release_i,
  input  logic [ADDR_W:0]   tx_data,
  output logic              irq_o,
  output logic              rx_valid_o,
  output logic [ADDR_W:0]   rx_data_o,
  output logic              ext_code_o,
  output logic              tx_mode_o
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  // line synchroniser: bit 1 = SCL, bit 0 = SDA
  logic [1:0] ln_now, ln_last;
  i2cw_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
    .now_o(ln_now), .last_o(ln_last));

  cfg_t cfg;
  i2cw_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .if_en(if_en),
    .d_i('{ack_en: ack_en, wait9: wait9_sel, stop_en: stop_irq_en, wake: wake_mode}),
    .q_o(cfg));

  logic scl, sda, scl_d, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl   = ln_now[1];
  assign sda   = ln_now[0];
  assign scl_d = ln_last[1];
  assign sda_d = ln_last[0];
  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;

  phase_t            phase;
  rel_act_t          rel_q;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] shreg, rxd_q;
  logic first_q, stretch_q, sda_q, irq_q, rxv_q, rw_q, ext_q, mack_q;
  logic is_ext, is_mine;

  assign cnt_n   = cnt + CNT_W'(1);
  assign is_ext  = (shreg[BYTE_W-1 -: 4] == EXT_NIBBLE);
  assign is_mine = (shreg[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; rel_q <= RA_NONE; cnt <= '0; shreg <= '0; rxd_q <= '0;
      first_q <= 1'b0; stretch_q <= 1'b0; sda_q <= 1'b0; irq_q <= 1'b0;
      rxv_q <= 1'b0; rw_q <= 1'b0; ext_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!if_en) begin
        phase <= PH_IDLE; rel_q <= RA_NONE; cnt <= '0; first_q <= 1'b0;
        stretch_q <= 1'b0; sda_q <= 1'b0; rxv_q <= 1'b0; ext_q <= 1'b0;
      end else if (start_c) begin
        phase <= PH_ADDR; rel_q <= RA_NONE; cnt <= '0; first_q <= 1'b1;
        stretch_q <= 1'b0; sda_q <= 1'b0; rxv_q <= 1'b0; ext_q <= 1'b0; rw_q <= 1'b0;
      end else if (stop_c) begin
        phase <= PH_IDLE; rel_q <= RA_NONE; cnt <= '0; first_q <= 1'b0;
        stretch_q <= 1'b0; sda_q <= 1'b0; rxv_q <= 1'b0;
        irq_q <= cfg.stop_en & ~cfg.wake;
      end else if (stretch_q) begin
        if (release_i) begin
          stretch_q <= 1'b0;
          rxv_q     <= 1'b0;
          rel_q     <= RA_NONE;
          case (rel_q)
            RA_ACK:  sda_q <= cfg.ack_en;
            RA_LOAD: begin shreg <= tx_data; sda_q <= ~tx_data[BYTE_W-1]; end
            default: ;
          endcase
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise && !first_q) begin
          if (phase != PH_TX && cnt < LAST_BIT) shreg <= {shreg[BYTE_W-2:0], sda};
          if (phase == PH_TX && cnt == LAST_BIT) mack_q <= ~sda;
        end
        if (scl_fall) begin
          if (first_q) begin
            first_q <= 1'b0;
          end else begin
            cnt <= (cnt_n == ACK_BIT) ? '0 : cnt_n;
            unique case (phase)
              PH_ADDR: begin
                if (cnt_n == LAST_BIT) begin
                  if (is_ext) begin
                    ext_q <= 1'b1; stretch_q <= 1'b1; irq_q <= 1'b1; rel_q <= RA_ACK;
                  end else if (is_mine) begin
                    sda_q <= 1'b1; rw_q <= shreg[0];
                  end else begin
                    phase <= PH_IDLE;
                  end
                end else if (cnt_n == ACK_BIT) begin
                  sda_q <= 1'b0;
                  if (ext_q) begin
                    phase <= cfg.ack_en ? PH_RX : PH_IDLE;
                  end else begin
                    stretch_q <= 1'b1; irq_q <= 1'b1;
                    if (rw_q) begin phase <= PH_TX; rel_q <= RA_LOAD; end
                    else      phase <= PH_RX;
                  end
                end
              end
              PH_RX: begin
                if (cnt_n == LAST_BIT) begin
                  rxd_q <= shreg;
                  if (!cfg.wait9) begin
                    stretch_q <= 1'b1; irq_q <= 1'b1; rxv_q <= 1'b1; rel_q <= RA_ACK;
                  end else begin
                    sda_q <= cfg.ack_en;
                  end
                end else if (cnt_n == ACK_BIT) begin
                  sda_q <= 1'b0;
                  if (cfg.wait9) begin stretch_q <= 1'b1; irq_q <= 1'b1; rxv_q <= 1'b1; end
                end
              end
              PH_TX: begin
                if (cnt_n < LAST_BIT) begin
                  shreg <= {shreg[BYTE_W-2:0], 1'b0};
                  sda_q <= ~shreg[BYTE_W-2];
                end else if (cnt_n == LAST_BIT) begin
                  sda_q <= 1'b0;
                  if (!cfg.wait9) begin stretch_q <= 1'b1; irq_q <= 1'b1; end
                end else begin
                  if (!mack_q) phase <= PH_IDLE;
                  else if (cfg.wait9) begin
                    stretch_q <= 1'b1; irq_q <= 1'b1; rel_q <= RA_LOAD;
                  end else begin
                    shreg <= tx_data; sda_q <= ~tx_data[BYTE_W-1];
                  end
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign scl_pull_o = stretch_q;
  assign sda_pull_o = sda_q;
  assign irq_o      = irq_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
  assign ext_code_o = ext_q;
  assign tx_mode_o  = (phase == PH_TX);

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (!scl_pull_o && !sda_pull_o && !irq_o)); // R1
  AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> irq_o); // R2
  AST_STOP_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && stop_c && cfg.wake) |=> !irq_o); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ACK_BIT); // R10
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && start_c) |=> (cnt == '0 && !scl_pull_o)); // R10
  AST_REL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o && release_i) |=> !scl_pull_o); // R11
  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !release_i) |=> $stable(rx_data_o)); // R11
endmodule

// File: tb/i2c_wait_slave_bench.sv
module i2c_wait_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl = 1'b0, m_sda = 1'b0;
  logic scl_pull, sda_pull, scl_bus, sda_bus;
  logic if_en = 0, ack_en = 0, wait9_sel = 0, stop_irq_en = 0, wake_mode = 0, release_i = 0;
  logic [7:0] tx_data = 8'h00;
  logic irq, rx_valid, ext_code, tx_mode;
  logic [7:0] rx_data;

  assign scl_bus = ~(m_scl | scl_pull);
  assign sda_bus = ~(m_sda | sda_pull);

  i2c_wait_slave u_i2c_wait_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr(OWN),
    .if_en(if_en), .ack_en(ack_en), .wait9_sel(wait9_sel),
    .stop_irq_en(stop_irq_en), .wake_mode(wake_mode), .release_i(release_i),
    .tx_data(tx_data), .irq_o(irq), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .ext_code_o(ext_code), .tx_mode_o(tx_mode));

  int total = 0, bad = 0, irq_cnt = 0;
  always @(posedge clk) if (irq) irq_cnt++;

  int hold_pt;
  logic hold_rxv, hold_ext;
  logic [7:0] hold_rxd, next_tx;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 0; waitc(HP);
    m_scl = 0; while (!scl_bus) waitc(1);
    waitc(HP); m_sda = 1; waitc(HP); m_scl = 1; waitc(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1; waitc(HP);
    m_scl = 0; while (!scl_bus) waitc(1);
    waitc(HP); m_sda = 0; waitc(HP);
  endtask

  task automatic one_bit(input logic drive_low, input int idx, output logic seen);
    m_sda = drive_low; waitc(HP);
    m_scl = 0; while (!scl_bus) waitc(1);
    waitc(HP/2); seen = sda_bus; waitc(HP/2);
    m_scl = 1; waitc(6);
    if (scl_pull) begin
      hold_pt = idx; hold_rxv = rx_valid; hold_rxd = rx_data; hold_ext = ext_code;
      waitc(4);
      release_i = 1; waitc(1); release_i = 0; waitc(2);
    end
  endtask

  task automatic xfer(input logic [7:0] ob, input logic rd, input logic mack,
                      output logic [7:0] ib, output logic ack);
    logic s;
    hold_pt = 0; hold_rxv = 0; hold_ext = 0;
    for (int i = 0; i < 8; i++) begin
      one_bit(rd ? 1'b0 : ~ob[7-i], i + 1, s);
      ib[7-i] = s;
      if (i == 7) tx_data = next_tx;
    end
    one_bit(rd ? mack : 1'b0, 9, s);
    ack = ~s;
  endtask

  task automatic set_cfg(logic a, logic w9, logic se, logic wk);
    if_en = 0; waitc(2);
    ack_en = a; wait9_sel = w9; stop_irq_en = se; wake_mode = wk;
    waitc(2); if_en = 1; waitc(2);
  endtask

  function automatic int exp_data_pt(logic w9);
    return w9 ? 9 : 8;
  endfunction

  // addr kinds: 0 own, 1 foreign, 2 extension
  task automatic addr_phase(input logic [7:0] ab, input int kind, input logic a,
                            input string tag);
    logic [7:0] ib; logic ack; int i0;
    i0 = irq_cnt;
    xfer(ab, 1'b0, 1'b0, ib, ack);
    check({tag, " addr hold point"}, hold_pt, kind == 0 ? 9 : kind == 2 ? 8 : 0);
    check({tag, " addr ack"}, ack, kind == 0 ? 1 : kind == 2 ? int'(a) : 0);
    check({tag, " addr irq"}, irq_cnt - i0, kind == 1 ? 0 : 1);
    if (kind == 2) check({tag, " R4 ext flag"}, hold_ext, 1);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic engaged, input logic a,
                         input logic w9, input string tag);
    logic [7:0] ib; logic ack; int i0;
    i0 = irq_cnt;
    xfer(d, 1'b0, 1'b0, ib, ack);
    check({tag, " data hold point"}, hold_pt, engaged ? exp_data_pt(w9) : 0);
    check({tag, " data ack"}, ack, engaged ? int'(a) : 0);
    check({tag, " data irq"}, irq_cnt - i0, engaged ? 1 : 0);
    if (engaged) begin
      check({tag, " R11 rx valid at hold"}, hold_rxv, 1);
      check({tag, " rx data"}, hold_rxd, d);
    end
  endtask

  task automatic rd_byte(input logic [7:0] d, input logic [7:0] nxt, input logic mack,
                         input logic w9, input string tag);
    logic [7:0] ib; logic ack; int i0;
    i0 = irq_cnt;
    next_tx = nxt;
    xfer(8'h00, 1'b1, mack, ib, ack);
    check({tag, " R7 tx byte"}, ib, d);
    check({tag, " R7 tx hold point"}, hold_pt, (!mack && w9) ? 0 : exp_data_pt(w9));
    check({tag, " R7 tx irq"}, irq_cnt - i0, (!mack && w9) ? 0 : 1);
  endtask

  task automatic stop_chk(input logic se, input logic wk, input string tag);
    int i0;
    i0 = irq_cnt;
    bus_stop(); waitc(6);
    check({tag, " R8 stop irq"}, irq_cnt - i0, (se && !wk) ? 1 : 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d0, d1, ab;
    logic s;
    int i0;
    void'($urandom(32'd20240611));
    next_tx = 8'h00;
    waitc(3); rst_n = 1; waitc(3);
    // R1 reset state
    check("R1 scl pull after reset", scl_pull, 0);
    check("R1 sda pull after reset", sda_pull, 0);
    check("R1 rx valid after reset", rx_valid, 0);
    // R1 disabled: matching address ignored
    i0 = irq_cnt;
    bus_start();
    addr_phase({OWN, 1'b0}, 1, 1'b0, "R1 disabled");
    bus_stop(); waitc(4);
    check("R1 no irq while disabled", irq_cnt - i0, 0);

    // R2 + R5: match, wait at 8
    set_cfg(1, 0, 1, 0);
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b1, "R2 match w8");
    for (int k = 0; k < 3; k++) wr_byte(8'($urandom), 1, 1, 0, "R5 w8");
    stop_chk(1, 0, "R8 enabled");

    // R2 + R6: ack_en=0 still acks address, data nacked, wait at 9
    set_cfg(0, 1, 1, 0);
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b0, "R2 match noack");
    for (int k = 0; k < 2; k++) wr_byte(8'($urandom), 1, 0, 1, "R6 w9 nack");
    stop_chk(1, 0, "R8 after w9");
    set_cfg(1, 1, 1, 0);
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b1, "R2 match w9");
    wr_byte(8'hA5, 1, 1, 1, "R6 w9 ack");
    stop_chk(1, 0, "R8 again");

    // R3 foreign address
    bus_start();
    addr_phase({7'h11, 1'b0}, 1, 1'b1, "R3 foreign");
    wr_byte(8'h3C, 0, 1, 1, "R3 ignored data");
    stop_chk(1, 0, "R8 foreign");

    // R4 extension code, ack enabled then disabled
    set_cfg(1, 0, 1, 0);
    bus_start();
    addr_phase(8'hF2, 2, 1'b1, "R4 ext ack");
    wr_byte(8'h5A, 1, 1, 0, "R4 ext data");
    stop_chk(1, 0, "R8 ext");
    set_cfg(0, 1, 1, 0);
    bus_start();
    addr_phase(8'hF7, 2, 1'b0, "R4 ext nack");
    wr_byte(8'h66, 0, 0, 1, "R4 ext ignored");
    stop_chk(1, 0, "R8 ext nack");

    // R7 reads in both wait modes
    for (int w = 0; w < 2; w++) begin
      set_cfg(1, w[0], 1, 0);
      d0 = 8'($urandom); d1 = 8'($urandom);
      next_tx = d0;
      bus_start();
      addr_phase({OWN, 1'b1}, 0, 1'b1, "R7 read addr");
      check("R7 tx mode", tx_mode, 1);
      rd_byte(d0, d1, 1'b1, w[0], "R7 first");
      rd_byte(d1, 8'h00, 1'b0, w[0], "R7 last");
      check("R7 sda released after nack", sda_pull, 0);
      stop_chk(1, 0, "R8 read");
    end

    // R8 suppression
    set_cfg(1, 0, 0, 0);
    bus_start(); addr_phase({OWN, 1'b0}, 0, 1'b1, "R8 se0");
    stop_chk(0, 0, "R8 disabled");
    set_cfg(1, 0, 1, 1);
    bus_start(); addr_phase({OWN, 1'b0}, 0, 1'b1, "R8 wake");
    stop_chk(1, 1, "R8 wake mute");

    // R9 inputs changed while enabled have no effect
    set_cfg(1, 0, 1, 0);
    ack_en = 0; wait9_sel = 1;
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b1, "R9 addr");
    wr_byte(8'hC3, 1, 1, 0, "R9 frozen cfg");
    stop_chk(1, 0, "R9 stop");

    // R10 repeated start mid-byte
    set_cfg(1, 1, 1, 0);
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b1, "R10 first addr");
    for (int b = 0; b < 3; b++) one_bit(b[0], b + 1, s);
    bus_start();
    addr_phase({OWN, 1'b0}, 0, 1'b1, "R10 restarted addr");
    wr_byte(8'h81, 1, 1, 1, "R10 after restart");
    stop_chk(1, 0, "R10 stop");

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic a, w9, se, wk, rd, eng;
      int kind, nb;
      a = 1'($urandom); w9 = 1'($urandom); se = 1'($urandom); wk = 1'($urandom);
      kind = int'($urandom_range(0, 2));
      rd = (kind == 0) ? 1'($urandom) : 1'b0;
      nb = int'($urandom_range(1, 3));
      set_cfg(a, w9, se, wk);
      if (kind == 0)      ab = {OWN, rd};
      else if (kind == 2) ab = {4'hF, 4'($urandom)};
      else                ab = {7'h20 + 7'($urandom_range(0, 15)), 1'($urandom)};
      d0 = 8'($urandom);
      next_tx = d0;
      bus_start();
      addr_phase(ab, kind, a, "RND");
      eng = (kind == 0) || (kind == 2 && a);
      for (int k = 0; k < nb; k++) begin
        if (rd) begin
          d1 = 8'($urandom);
          rd_byte(d0, d1, (k != nb - 1), w9, "RND read");
          d0 = d1;
        end else begin
          wr_byte(8'($urandom), eng, a, w9, "RND write");
        end
      end
      stop_chk(se, wk, "RND");
    end
    summary();
  end
endmodule